// File: doc/BRIEF.md
# Single-Bit Memory Access Unit

This block carries out single-bit operations on an 8-bit bit address space. Each request names a bit address, an operation and, for assignments, the bit value to store. The unit turns the bit address into the address of the byte that holds the bit and the bit's position within that byte. Bit addresses below 0x80 fall into a sixteen-byte window of internal RAM. Bit addresses at or above 0x80 fall onto special-function register bytes whose addresses are multiples of eight.

Byte traffic goes over one shared port toward RAM and register space. Reads on this port are combinational, and writes take effect on the clock edge. A pure test spends one read beat on the port. An assignment or a complement reads the containing byte in its first cycle. In the next cycle it writes the whole byte back with only the addressed bit changed, and `busy` stays high during that write beat.

There is also a latched test operation, used for conditional and logic tests. When the containing byte is one of the I/O port registers, this operation gates the bit it reads with the matching bit of that port's output latch.

Top module: `bit_access_unit`

## Requirements
- R1: A bit address `a` below 0x80 reads byte 0x20 + `a[6:3]` on the memory port. The bit position is `a[2:0]`.
- R2: A bit address `a` at or above 0x80 reads byte `{a[7:3],3'b000}`. The bit position is `a[2:0]`.
- R3: An accepted test (op 0) raises `bit_valid` for exactly one cycle, in the cycle after acceptance, with `bit_out` equal to the addressed bit. A test causes no write beat.
- R4: An accepted assignment (op 1) is followed one cycle later by a write beat. The write beat uses the same byte address and writes the read byte with only the addressed bit replaced by `req_wval`.
- R5: An accepted complement (op 2) writes back the read byte with the addressed bit inverted, as captured in the read beat.
- R6: `busy` is high for exactly the one write-beat cycle. A request presented while `busy` is high is ignored: it gets no read beat, no result and no write.
- R7: A latched test (op 3) of a byte at 0x80, 0x90, 0xA0 or 0xB0 (port k = 0..3 in that order) returns the memory bit ANDed with `latch_bits[k*8 + a[2:0]]`.
- R8: A latched test of any other byte returns the memory bit unmasked.
- R9: `mem_wr_en` is high only in the cycle after an accepted assignment or complement. A cycle with `req_valid` low that does not follow such a request has no write.
- R10: While reset is held, `busy`, `mem_wr_en`, `mem_rd_en`, `bit_valid` and `bit_out` are all low.
- R11: For assignment and complement, `bit_out` reports the bit value before modification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 8 | Bit address |
| req_op | input | 2 | 0 test, 1 assign, 2 complement, 3 latched test |
| req_wval | input | 1 | Value stored by an assignment |
| latch_bits | input | 32 | Port output latches, port k in bits k*8+7..k*8 |
| busy | output | 1 | Write beat in progress; requests ignored |
| mem_rd_en | output | 1 | Read beat on the byte port |
| mem_addr | output | 8 | Byte address |
| mem_rdata | input | 8 | Byte read data (same cycle) |
| mem_wr_en | output | 1 | Write beat on the byte port |
| mem_wdata | output | 8 | Byte write data |
| bit_out | output | 1 | Bit result |
| bit_valid | output | 1 | Result strobe |

## Verification
Every one of the 256 bit addresses is swept under all four operations. This covers the 0x7F/0x80 boundary, where a design with a wrong split would address RAM byte 0x2F+ or miss SFR alignment. It also covers bit positions 0 and 7, where a shifted mask would corrupt neighbouring bits in the write-back byte.

The latched test is swept twice, with one latch pattern and then its inverse. This exposes a port decoder that matches non-port SFR bytes or selects the wrong latch lane. A request held during the write beat shows whether a design wrongly accepts it, which would produce a spurious read and a lost update.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;

  localparam int BYTE_W = 8;
  localparam int POS_W  = 3;

  typedef enum logic [1:0] {
    OP_TEST       = 2'd0,
    OP_ASSIGN     = 2'd1,
    OP_FLIP       = 2'd2,
    OP_TEST_LATCH = 2'd3
  } bit_op_e;

  // Byte that contains a bit: RAM window below the split, aligned SFR above.
  function automatic logic [BYTE_W-1:0] bit_home(input logic [BYTE_W-1:0] baddr,
                                                  input logic [BYTE_W-1:0] ram_base);
    logic [BYTE_W-1:0] r;
    if (baddr[BYTE_W-1]) r = {baddr[BYTE_W-1:POS_W], {POS_W{1'b0}}};
    else                 r = ram_base + {{(POS_W+1){1'b0}}, baddr[BYTE_W-2:POS_W]};
    return r;
  endfunction

  // New byte for a modifying operation; tests return the byte unchanged.
  function automatic logic [BYTE_W-1:0] bit_apply(input logic [BYTE_W-1:0] old_byte,
                                                   input logic [POS_W-1:0]  pos,
                                                   input bit_op_e           op,
                                                   input logic              wval);
    logic [BYTE_W-1:0] r;
    r = old_byte;
    case (op)
      OP_ASSIGN: r[pos] = wval;
      OP_FLIP:   r[pos] = ~old_byte[pos];
      default:   r = old_byte;
    endcase
    return r;
  endfunction

  function automatic logic op_modifies(input bit_op_e op);
    return (op == OP_ASSIGN) || (op == OP_FLIP);
  endfunction

endpackage

// File: rtl/bitacc_map.sv
module bitacc_map
  import bitacc_pkg::*;
#(
  parameter logic [7:0] RAM_BASE    = 8'h20,
  parameter int         NUM_PORTS   = 4,
  parameter logic [7:0] PORT_BASE   = 8'h80,
  parameter logic [7:0] PORT_STRIDE = 8'h10,
  localparam int        PIDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [BYTE_W-1:0] bit_addr,
  output logic [BYTE_W-1:0] byte_addr,
  output logic [POS_W-1:0]  bit_pos,
  output logic              port_hit,
  output logic [PIDX_W-1:0] port_sel
);

  logic [NUM_PORTS-1:0] port_match;

  assign byte_addr = bit_home(bit_addr, RAM_BASE);
  assign bit_pos   = bit_addr[POS_W-1:0];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam logic [BYTE_W-1:0] PADDR = PORT_BASE + BYTE_W'(k) * PORT_STRIDE;
    assign port_match[k] = bit_addr[BYTE_W-1] && (byte_addr == PADDR);
  end

  assign port_hit = |port_match;

  always_comb begin
    port_sel = '0;
    for (int k = 0; k < NUM_PORTS; k++) begin
      if (port_match[k]) port_sel = PIDX_W'(k);
    end
  end

endmodule

// File: rtl/bitacc_modify.sv
module bitacc_modify
  import bitacc_pkg::*;
(
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [POS_W-1:0]  bit_pos,
  input  bit_op_e           op,
  input  logic              wval,
  output logic [BYTE_W-1:0] new_byte,
  output logic              old_bit
);

  assign old_bit  = old_byte[bit_pos];
  assign new_byte = bit_apply(old_byte, bit_pos, op, wval);

endmodule

// File: rtl/bitacc_seq.sv
module bitacc_seq
  import bitacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              modify,
  input  logic [BYTE_W-1:0] byte_addr,
  input  logic [BYTE_W-1:0] new_byte,
  input  logic              res_bit,
  output logic              busy,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              res_q,
  output logic              res_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      res_q     <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      busy      <= accept && modify;
      res_valid <= accept;
      if (accept) begin
        res_q   <= res_bit;
        wr_addr <= byte_addr;
        wr_data <= new_byte;
      end
    end
  end

endmodule

// File: rtl/bit_access_unit.sv
module bit_access_unit
  import bitacc_pkg::*;
#(
  parameter logic [7:0] RAM_BASE    = 8'h20,
  parameter int         NUM_PORTS   = 4,
  parameter logic [7:0] PORT_BASE   = 8'h80,
  parameter logic [7:0] PORT_STRIDE = 8'h10,
  localparam int        LATCH_W     = NUM_PORTS * 8,
  localparam int        PIDX_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [7:0]         req_addr,
  input  logic [1:0]         req_op,
  input  logic               req_wval,
  input  logic [LATCH_W-1:0] latch_bits,
  output logic               busy,
  output logic               mem_rd_en,
  output logic [7:0]         mem_addr,
  input  logic [7:0]         mem_rdata,
  output logic               mem_wr_en,
  output logic [7:0]         mem_wdata,
  output logic               bit_out,
  output logic               bit_valid
);

  bit_op_e           op;
  logic [7:0]        map_byte;
  logic [POS_W-1:0]  map_pos;
  logic              port_hit;
  logic [PIDX_W-1:0] port_sel;
  logic [7:0]        new_byte;
  logic              old_bit;
  logic              latch_bit;
  logic              res_bit;
  logic [7:0]        wr_addr;
  logic [7:0]        wr_data;

  // Named events for the checker.
  logic accept_fire;
  logic modify_fire;
  logic flip_fire;

  assign op          = bit_op_e'(req_op);
  assign accept_fire = req_valid && !busy;
  assign modify_fire = accept_fire && op_modifies(op);
  assign flip_fire   = accept_fire && (op == OP_FLIP);

  bitacc_map #(
    .RAM_BASE(RAM_BASE), .NUM_PORTS(NUM_PORTS),
    .PORT_BASE(PORT_BASE), .PORT_STRIDE(PORT_STRIDE)
  ) u_map (
    .bit_addr (req_addr),
    .byte_addr(map_byte),
    .bit_pos  (map_pos),
    .port_hit (port_hit),
    .port_sel (port_sel)
  );

  bitacc_modify u_mod (
    .old_byte(mem_rdata),
    .bit_pos (map_pos),
    .op      (op),
    .wval    (req_wval),
    .new_byte(new_byte),
    .old_bit (old_bit)
  );

  assign latch_bit = latch_bits[{port_sel, map_pos}];
  assign res_bit   = (op == OP_TEST_LATCH && port_hit) ? (old_bit & latch_bit) : old_bit;

  bitacc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept_fire),
    .modify   (op_modifies(op)),
    .byte_addr(map_byte),
    .new_byte (new_byte),
    .res_bit  (res_bit),
    .busy     (busy),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .res_q    (bit_out),
    .res_valid(bit_valid)
  );

  assign mem_rd_en = accept_fire && rst_n;
  assign mem_addr  = busy ? wr_addr : map_byte;
  assign mem_wr_en = busy;
  assign mem_wdata = wr_data;

endmodule

// File: rtl/bitacc_checker.sv
module bitacc_checker #(
  parameter logic [7:0] RAM_BASE = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_addr_msb,
  input logic       busy,
  input logic       mem_rd_en,
  input logic [7:0] mem_addr,
  input logic [7:0] mem_rdata,
  input logic       mem_wr_en,
  input logic [7:0] mem_wdata,
  input logic       bit_valid,
  input logic       modify_fire,
  input logic       flip_fire
);

  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !busy);

  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_wr_after_modify_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(modify_fire));

  assert_wr_same_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_addr == $past(mem_addr));

  assert_one_bit_delta_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $onehot0(mem_wdata ^ $past(mem_rdata)));

  assert_flip_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && $past(flip_fire)) |-> $countones(mem_wdata ^ $past(mem_rdata)) == 1);

  assert_ram_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !req_addr_msb) |-> (mem_addr - RAM_BASE) < 8'd16);

  assert_sfr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && req_addr_msb) |-> (mem_addr[7] && mem_addr[2:0] == 3'b000));

  assert_result_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(mem_rd_en));

endmodule

bind bit_access_unit bitacc_checker #(.RAM_BASE(RAM_BASE)) u_bitacc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_addr_msb(req_addr[7]),
  .busy        (busy),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .mem_wr_en   (mem_wr_en),
  .mem_wdata   (mem_wdata),
  .bit_valid   (bit_valid),
  .modify_fire (modify_fire),
  .flip_fire   (flip_fire)
);

// File: tb/test_bit_access_unit.sv
module test_bit_access_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_op = '0;
  logic        req_wval = 1'b0;
  logic [31:0] latch_bits = 32'h96F03CA5;
  logic        busy, mem_rd_en, mem_wr_en, bit_out, bit_valid;
  logic [7:0]  mem_addr, mem_rdata, mem_wdata;

  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 29) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (mem_wr_en) begin
      mem[mem_addr] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr];

  bit_access_unit i_bit_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_wval(req_wval), .latch_bits(latch_bits),
    .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] home_of(input logic [7:0] a);
    if (a >= 8'h80) return a & 8'hF8;
    return 8'h20 + 8'(a >> 3);
  endfunction

  function automatic logic is_port(input logic [7:0] b);
    return b == 8'h80 || b == 8'h90 || b == 8'hA0 || b == 8'hB0;
  endfunction

  task automatic run_op(input logic [7:0] a, input logic [1:0] op, input logic wv);
    logic [7:0] hb, old, nb;
    logic [2:0] p;
    logic ob, exp_res;
    int port_k;
    hb = home_of(a);
    p = a[2:0];
    old = shadow[hb];
    ob = old[p];
    nb = old;
    if (op == 2'd1) nb[p] = wv;
    if (op == 2'd2) nb[p] = ~ob;
    exp_res = ob;
    if (op == 2'd3 && is_port(hb)) begin
      port_k = (int'(hb) - 'h80) / 16;
      exp_res = ob & latch_bits[port_k*8 + int'(p)];
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = op; req_wval = wv;
    #1;
    if (a < 8'h80) chk(mem_rd_en && mem_addr == hb, "R1 byte map", int'(mem_addr), int'(hb));
    else           chk(mem_rd_en && mem_addr == hb, "R2 byte map", int'(mem_addr), int'(hb));
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    case (op)
      2'd0: chk(bit_valid && bit_out == exp_res, "R3 test result", int'(bit_out), int'(exp_res));
      2'd3: if (is_port(hb)) chk(bit_valid && bit_out == exp_res, "R7 latched port test", int'(bit_out), int'(exp_res));
            else chk(bit_valid && bit_out == exp_res, "R8 unmasked latched test", int'(bit_out), int'(exp_res));
      default: chk(bit_valid && bit_out == ob, "R11 old bit reported", int'(bit_out), int'(ob));
    endcase
    if (op == 2'd1 || op == 2'd2) begin
      chk(busy && mem_wr_en && mem_addr == hb, "R4 write beat address", int'(mem_addr), int'(hb));
      if (op == 2'd1) chk(mem_wdata == nb, "R4 assign byte", int'(mem_wdata), int'(nb));
      else            chk(mem_wdata == nb, "R5 complement byte", int'(mem_wdata), int'(nb));
      shadow[hb] = nb;
    end else begin
      chk(!mem_wr_en && !busy, "R9 no write after test", int'(mem_wr_en), 0);
    end
    @(negedge clk);
    #1;
    chk(!busy && !bit_valid && !mem_wr_en, "R6 busy and strobe drop", int'({busy, bit_valid, mem_wr_en}), 0);
    chk(mem[hb] == shadow[hb], "R4 memory content", int'(mem[hb]), int'(shadow[hb]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = init_val(i);
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !mem_wr_en && !mem_rd_en && !bit_valid && !bit_out, "R10 reset state",
        int'({busy, mem_wr_en, mem_rd_en, bit_valid, bit_out}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 256; a++) run_op(8'(a), 2'd0, 1'b0);
    for (int a = 0; a < 256; a++) run_op(8'(a), 2'd1, a[0] ^ a[3]);
    for (int a = 0; a < 256; a++) run_op(8'(a), 2'd2, 1'b0);
    for (int a = 0; a < 256; a++) run_op(8'(a), 2'd3, 1'b0);
    latch_bits = ~latch_bits;
    for (int a = 0; a < 256; a++) run_op(8'(a), 2'd3, 1'b1);

    // R6: request held during the write beat is ignored.
    begin
      logic [7:0] nb;
      nb = shadow[8'h20];
      nb[0] = ~nb[0];
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'h00; req_op = 2'd2; req_wval = 1'b0;
      @(negedge clk);
      req_addr = 8'h10; req_op = 2'd1; req_wval = ~shadow[8'h22][0];
      #1;
      chk(busy && !mem_rd_en && mem_addr == 8'h20, "R6 request ignored while busy", int'(mem_addr), 'h20);
      shadow[8'h20] = nb;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!bit_valid && !mem_wr_en, "R6 no result for ignored request", int'({bit_valid, mem_wr_en}), 0);
      chk(mem[8'h22] == shadow[8'h22], "R6 ignored byte unchanged", int'(mem[8'h22]), int'(shadow[8'h22]));
      chk(mem[8'h20] == shadow[8'h20], "R5 complement before ignored request", int'(mem[8'h20]), int'(shadow[8'h20]));
    end

    // R9: idle cycles never write.
    repeat (4) begin
      @(negedge clk);
      #1;
      chk(!mem_wr_en && !mem_rd_en, "R9 idle no write", int'(mem_wr_en), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired R3 actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule